// File: doc/BRIEF.md
# Programmable Memory Window Decoder

This block decides, for each memory access arriving from an upstream bus, whether one of four programmable address windows claims it. It also reports which window claimed it and whether the access should be routed through the line buffers. Each window is a single 32-bit register holding a 16-bit lower bound and a 16-bit upper bound. Both bounds are compared against address bits 31:16, so windows are placed and sized in 64 KB steps anywhere in the 4 GB space.

Software programs the windows, and a small attribute register with one buffering flag per window, through a simple register port. Writes land on the next clock edge. Reads return the stored value combinationally. The lookup port takes a 32-bit address every cycle and presents the decision one cycle later. A global line-buffer enable input overrides every per-window buffering flag. After reset all windows are empty because each lower bound sits above its upper bound.

Top module: `mwin_decoder`

## Requirements
- R1: After reset every window register reads 32'h0000FFFF, the attribute register reads 0, and no lookup address produces a hit.
- R2: Window k (k = 0..3) sits at register offset 8'h60 + 4*k. A write with `cfg_we` high updates it at the next rising clock edge, and `cfg_rdata` returns its value. Any offset that maps to no register reads 0, and writes to it change no register.
- R3: The attribute register sits at offset 8'h74. Bits 3:0 are the buffering flags, with bit k belonging to window k. Bits 31:4 of the read data are always 0, and writes to them are ignored.
- R4: Within a window register, bits 31:16 are the upper bound and bits 15:0 are the lower bound. Window k matches an address A when lower ≤ A[31:16] ≤ upper, with both bounds inclusive.
- R5: The lookup outputs `hit`, `win_idx` and `buffered` are registered. They reflect the lookup address and `lbuf_en` sampled at the previous rising clock edge.
- R6: When several windows match, the lowest-numbered window wins. `win_idx` reports its number k as a 2-bit binary value.
- R7: On a hit, `buffered` equals the attribute flag of the winning window ANDed with `lbuf_en`. When `lbuf_en` is 0, `buffered` is 0 whatever the flags hold.
- R8: When no window matches, `hit`, `win_idx` and `buffered` are all 0.
- R9: A window whose lower bound exceeds its upper bound matches nothing. A window with lower bound 16'h0000 and upper bound 16'hFFFF matches every address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_addr | input | 8 | Register byte offset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| lbuf_en | input | 1 | Global line-buffer enable |
| lk_addr | input | 32 | Lookup access address |
| hit | output | 1 | Some window claims the access |
| win_idx | output | 2 | Number of the winning window |
| buffered | output | 1 | Access goes through the line buffers |

## Verification
A corrupted bound register shows up in two places: the register read of that offset, and a lookup at an address just inside or just outside the bound. The lookup exposes it on the `hit` output one cycle after the address is applied. A faulty priority chain or attribute selection shows on `win_idx` or `buffered` for an address inside overlapping windows, also one cycle later. Because of this, the tests probe each bound at its exact edge and one step beyond, on both sides.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  localparam int NUM_WIN    = 4;
  localparam int ADDR_W     = 32;
  localparam int FIELD_W    = 16;
  localparam int REG_W      = 32;
  localparam int CFG_AW     = 8;
  localparam int IDX_W      = $clog2(NUM_WIN);
  localparam logic [CFG_AW-1:0] WIN_OFF  = 8'h60;
  localparam logic [CFG_AW-1:0] ATTR_OFF = 8'h74;

  typedef struct packed {
    logic [FIELD_W-1:0] upper;
    logic [FIELD_W-1:0] lower;
  } win_reg_t;

  localparam win_reg_t WIN_RESET = '{upper: 16'h0000, lower: 16'hFFFF};
endpackage

// File: rtl/mwin_rst_sync.sv
module mwin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mwin_regfile.sv
module mwin_regfile
  import mwin_pkg::*;
#(
  parameter int N = NUM_WIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output win_reg_t          win_o [N],
  output logic [N-1:0]      attr_o
);
  localparam int SPAN = N * 4;
  localparam int SW   = (N > 1) ? $clog2(N) : 1;

  logic [CFG_AW-1:0] rel_off;
  logic              win_sel;
  logic [SW-1:0]     win_num;
  logic              attr_sel;
  logic [N-1:0]      win_wen;
  logic              attr_wen;

  always_comb begin
    rel_off  = cfg_addr - WIN_OFF;
    win_sel  = (int'(rel_off) < SPAN) && (rel_off[1:0] == 2'b00);
    win_num  = rel_off[SW+1:2];
    attr_sel = (cfg_addr == ATTR_OFF);
    attr_wen = cfg_we && attr_sel;
    for (int k = 0; k < N; k++) begin
      win_wen[k] = cfg_we && win_sel && (int'(win_num) == k);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_win
    win_reg_t win_q;
    win_reg_t win_d;

    always_comb begin
      win_d = win_q;
      if (win_wen[g]) win_d = win_reg_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= WIN_RESET;
      else        win_q <= win_d;
    end

    assign win_o[g] = win_q;

    // R2
    win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_wen[g] |=> (win_q == $past(cfg_wdata)));
  end

  logic [N-1:0] attr_q;
  logic [N-1:0] attr_d;

  always_comb begin
    attr_d = attr_q;
    if (attr_wen) attr_d = cfg_wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attr_q <= '0;
    else        attr_q <= attr_d;
  end

  assign attr_o = attr_q;

  always_comb begin
    cfg_rdata = '0;
    if (win_sel) begin
      for (int k = 0; k < N; k++) begin
        if (int'(win_num) == k) cfg_rdata = win_o[k];
      end
    end else if (attr_sel) begin
      cfg_rdata[N-1:0] = attr_q;
    end
  end

  // R3
  attr_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attr_sel |-> (cfg_rdata[REG_W-1:N] == '0));

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_wen, attr_wen}));
endmodule

// File: rtl/mwin_match.sv
module mwin_match
  import mwin_pkg::*;
#(
  parameter int N = NUM_WIN
) (
  input  logic [ADDR_W-1:0] lk_addr,
  input  win_reg_t          win_i [N],
  output logic [N-1:0]      match_o
);
  localparam int HI = ADDR_W - 1;
  localparam int LO = ADDR_W - FIELD_W;

  logic [FIELD_W-1:0] page;
  assign page = lk_addr[HI:LO];

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic above_lower;
    logic below_upper;
    always_comb begin
      above_lower = (page >= win_i[g].lower);
      below_upper = (page <= win_i[g].upper);
      match_o[g]  = above_lower && below_upper;
    end
  end
endmodule

// File: rtl/mwin_select.sv
module mwin_select
  import mwin_pkg::*;
#(
  parameter int N = NUM_WIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     match_i,
  input  logic [N-1:0]     attr_i,
  input  logic             lbuf_en,
  output logic             hit,
  output logic [IDX_W-1:0] win_idx,
  output logic             buffered
);
  logic [N-1:0]     grant;
  logic             any_match;
  logic             hit_d;
  logic [IDX_W-1:0] idx_d;
  logic             buf_d;
  logic             found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    idx_d = '0;
    for (int k = 0; k < N; k++) begin
      if (match_i[k] && !found) begin
        grant[k] = 1'b1;
        idx_d    = IDX_W'(k);
        found    = 1'b1;
      end
    end
    any_match = |match_i;
    hit_d     = any_match;
    buf_d     = lbuf_en && |(grant & attr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      win_idx  <= '0;
      buffered <= 1'b0;
    end else begin
      hit      <= hit_d;
      win_idx  <= idx_d;
      buffered <= buf_d;
    end
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant == '0) == (match_i == '0)));

  // R5
  hit_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |=> hit);

  // R5
  miss_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_match |=> !hit);

  // R7
  buf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lbuf_en |=> !buffered);

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (win_idx == '0 && !buffered));
endmodule

// File: rtl/mwin_decoder.sv
module mwin_decoder
  import mwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              lbuf_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  win_idx,
  output logic              buffered
);
  logic             rst_sync_n;
  win_reg_t         win_w [NUM_WIN];
  logic [NUM_WIN-1:0] attr_w;
  logic [NUM_WIN-1:0] match_w;

  mwin_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mwin_regfile #(.N(NUM_WIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_addr  (cfg_addr),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .win_o     (win_w),
    .attr_o    (attr_w)
  );

  mwin_match #(.N(NUM_WIN)) u_match (
    .lk_addr (lk_addr),
    .win_i   (win_w),
    .match_o (match_w)
  );

  mwin_select #(.N(NUM_WIN)) u_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .match_i  (match_w),
    .attr_i   (attr_w),
    .lbuf_en  (lbuf_en),
    .hit      (hit),
    .win_idx  (win_idx),
    .buffered (buffered)
  );
endmodule

// File: tb/mwin_decoder_bench.sv
module mwin_decoder_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        lbuf_en;
  logic [31:0] lk_addr;
  logic        hit;
  logic [1:0]  win_idx;
  logic        buffered;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwin_decoder u_mwin_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lbuf_en(lbuf_en),
    .lk_addr(lk_addr), .hit(hit), .win_idx(win_idx), .buffered(buffered)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  // Apply address at a falling edge, registered at the next rising edge, sample at the falling edge after.
  task automatic look(input string req, input logic [31:0] a, input logic eh,
                      input logic [1:0] ei, input logic eb);
    @(negedge clk);
    lk_addr = a;
    @(negedge clk);
    check(req, {29'd0, hit, win_idx}, {29'd0, eh, ei});
    check(req, {31'd0, buffered}, {31'd0, eb});
  endtask

  task automatic win(input int k, input logic [15:0] lo, input logic [15:0] hi);
    wr(8'h60 + 8'(4*k), {hi, lo});
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) rd_chk("R1", 8'h60 + 8'(4*k), 32'h0000FFFF);
    rd_chk("R1", 8'h74, 32'h0);
    look("R1", 32'h0000_0000, 1'b0, 2'd0, 1'b0);
    look("R1", 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0);
    look("R1", 32'h1234_5678, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_regs();
    win(0, 16'h0010, 16'h001F);
    win(1, 16'h0100, 16'h01FF);
    win(2, 16'h8000, 16'h80FF);
    win(3, 16'hF000, 16'hF00F);
    rd_chk("R2", 8'h60, 32'h001F_0010);
    rd_chk("R2", 8'h64, 32'h01FF_0100);
    rd_chk("R2", 8'h68, 32'h80FF_8000);
    rd_chk("R2", 8'h6C, 32'hF00F_F000);
    wr(8'h62, 32'hDEAD_BEEF);
    wr(8'h70, 32'hDEAD_BEEF);
    rd_chk("R2", 8'h62, 32'h0);
    rd_chk("R2", 8'h70, 32'h0);
    rd_chk("R2", 8'h5C, 32'h0);
    rd_chk("R2", 8'h60, 32'h001F_0010);
    rd_chk("R2", 8'h6C, 32'hF00F_F000);
  endtask

  task automatic t_attr();
    wr(8'h74, 32'hFFFF_FFF5);
    rd_chk("R3", 8'h74, 32'h0000_0005);
    wr(8'h74, 32'h0000_00F0);
    rd_chk("R3", 8'h74, 32'h0);
  endtask

  task automatic t_bounds();
    lbuf_en = 1'b0;
    look("R4", 32'h000F_FFFF, 1'b0, 2'd0, 1'b0);
    look("R4", 32'h0010_0000, 1'b1, 2'd0, 1'b0);
    look("R4", 32'h001F_FFFF, 1'b1, 2'd0, 1'b0);
    look("R4", 32'h0020_0000, 1'b0, 2'd0, 1'b0);
    look("R4", 32'h80FF_1234, 1'b1, 2'd2, 1'b0);
    look("R4", 32'hF00F_FFFF, 1'b1, 2'd3, 1'b0);
    look("R8", 32'h4000_0000, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    lk_addr = 32'h0100_0000;
    #1;
    // R5: old miss still held before the edge
    check("R5", {31'd0, hit}, 32'd0);
    @(negedge clk);
    check("R5", {29'd0, hit, win_idx}, {29'd0, 1'b1, 2'd1});
  endtask

  task automatic t_buffer();
    wr(8'h74, 32'h0000_000A);
    lbuf_en = 1'b1;
    look("R7", 32'h0100_0000, 1'b1, 2'd1, 1'b1);
    look("R7", 32'h0010_0000, 1'b1, 2'd0, 1'b0);
    look("R7", 32'hF000_0000, 1'b1, 2'd3, 1'b1);
    look("R8", 32'h4000_0000, 1'b0, 2'd0, 1'b0);
    lbuf_en = 1'b0;
    look("R7", 32'h0100_0000, 1'b1, 2'd1, 1'b0);
    look("R7", 32'hF000_0000, 1'b1, 2'd3, 1'b0);
  endtask

  task automatic t_priority();
    lbuf_en = 1'b1;
    win(2, 16'h0000, 16'hFFFF);
    look("R6", 32'h0100_0000, 1'b1, 2'd1, 1'b1);
    look("R6", 32'h0015_0000, 1'b1, 2'd0, 1'b0);
    look("R9", 32'h4000_0000, 1'b1, 2'd2, 1'b0);
    look("R9", 32'hFFFF_FFFF, 1'b1, 2'd2, 1'b0);
    win(0, 16'h0000, 16'h0000);
    look("R6", 32'h0000_FFFF, 1'b1, 2'd0, 1'b0);
  endtask

  task automatic t_empty();
    win(2, 16'h5001, 16'h5000);
    win(0, 16'h0001, 16'h0000);
    look("R9", 32'h5000_0000, 1'b0, 2'd0, 1'b0);
    look("R9", 32'h5001_0000, 1'b0, 2'd0, 1'b0);
    look("R9", 32'h0000_0000, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_addr = 8'h0; cfg_we = 1'b0; cfg_wdata = '0;
    lbuf_en = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_attr();
    t_bounds();
    t_latency();
    t_buffer();
    t_priority();
    t_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule